// File: doc/BRIEF.md
# One-Time-Programmable Trim Controller

This block holds the working configuration of a sensor front end: a 3-bit filter code and a 6-bit gain trim. It takes write commands that a serial port has already decoded, together with single-cycle strobes for the falling and the rising edge of the frame select. A preview write replaces the working configuration without touching non-volatile storage. A program write schedules a burn of the same fields into a fuse array that sits outside the block. The burn is issued as a one-cycle programming strobe when the next frame begins.

The block also times each conversion from the frame start and exposes a strobe at the end of each conversion. New preview settings take effect at that strobe. After reset, and after every programming pulse, the working configuration is reloaded from the fuse read port. Burned settings therefore survive a reset. Fuse bits only ever go from 0 to 1, so a burn leaves the stored value equal to the old contents OR the new ones. A larger gain code means more sensitivity: 0 is the lowest gain and 63 the highest, in steps of about 0.8 %.

Top module: `otp_trim_ctrl`

## Requirements
- R1: While `rst_n` is low, `filt_code`, `gain_trim`, `fuse_pgm`, `conv_end` and `prog_err` are all 0.
- R2: On the first clock edge after reset is released, `{filt_code, gain_trim}` is loaded from `fuse_q`.
- R3: A preview write (`cmd_wr`=1, `cmd_prog`=0, sampled with `cs_rise`) becomes visible on the edge that closes the first `conv_end` cycle that lies strictly after that `cs_rise` cycle. Until then the outputs keep their old value.
- R4: `conv_end` is high for exactly one cycle: the cycle after CONV_CYCLES−1 edges have passed since the edge that sampled `cs_fall`. With CONV_CYCLES=8, it is sampled high 7 edges after the `cs_fall` edge.
- R5: A program write (`cmd_wr`=1, `cmd_prog`=1) raises no strobe in its own frame. `fuse_pgm` rises on the edge that samples the next `cs_fall`, and `fuse_wdata` carries the written value packed as {filter[2:0], gain[5:0]}.
- R6: `fuse_pgm` lasts exactly one clock cycle per programming request.
- R7: Two edges after a programming pulse starts, the outputs equal the fuse contents, which are the old contents OR the written value.
- R8: A program write in the frame right after an accepted program write is dropped: no second pulse follows. `prog_err` is then set and stays high until reset.
- R9: Fuse contents burned before a reset appear on the outputs after that reset.
- R10: A program write does not change the working configuration before its pulse. A frame with `cmd_wr`=0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_fall | input | 1 | One-cycle strobe: frame select went active |
| cs_rise | input | 1 | One-cycle strobe: frame select released; command fields valid |
| cmd_wr | input | 1 | Frame carried a write command |
| cmd_prog | input | 1 | Write requests a fuse burn |
| cmd_filt | input | 3 | Filter code of the write |
| cmd_gain | input | 6 | Gain trim of the write |
| fuse_q | input | 9 | Fuse read port, {filter, gain} |
| fuse_pgm | output | 1 | One-cycle programming strobe |
| fuse_wdata | output | 9 | Bits to burn, {filter, gain} |
| filt_code | output | 3 | Working filter code |
| gain_trim | output | 6 | Working gain trim |
| conv_end | output | 1 | End-of-conversion strobe |
| prog_err | output | 1 | Sticky: a back-to-back program write was dropped |

## Verification
The bench sweeps all 512 preview values. It checks that each value stays hidden until the conversion end and then appears. A design that applied writes at `cs_rise` would expose them 4 cycles early. It also drops `cs_rise` onto the very cycle of `conv_end`, so a design that applied a write within that cycle is caught a whole frame early. Burns whose bits overlap with earlier burns expose a controller that overwrites instead of accumulating. Back-to-back program writes expose a second pulse or a missing error. Repeated resets show whether burned values are reloaded.

// File: rtl/otp_trim_ctrl.sv
module otp_trim_ctrl #(
  parameter int FILT_W      = 3,
  parameter int GAIN_W      = 6,
  parameter int CONV_CYCLES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_fall,
  input  logic                     cs_rise,
  input  logic                     cmd_wr,
  input  logic                     cmd_prog,
  input  logic [FILT_W-1:0]        cmd_filt,
  input  logic [GAIN_W-1:0]        cmd_gain,
  input  logic [FILT_W+GAIN_W-1:0] fuse_q,
  output logic                     fuse_pgm,
  output logic [FILT_W+GAIN_W-1:0] fuse_wdata,
  output logic [FILT_W-1:0]        filt_code,
  output logic [GAIN_W-1:0]        gain_trim,
  output logic                     conv_end,
  output logic                     prog_err
);
  localparam int CFG_W = FILT_W + GAIN_W;
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);

  logic [CNT_W-1:0] conv_cnt;
  logic [CFG_W-1:0] act_cfg, prev_cfg, burn_cfg;
  logic             prev_v, burn_v, after_burn, reload_q, boot_q;
  logic [CFG_W-1:0] cmd_cfg;

  assign cmd_cfg   = {cmd_filt, cmd_gain};
  assign conv_end  = rst_n && (conv_cnt == CNT_W'(1));
  assign filt_code = act_cfg[CFG_W-1:GAIN_W];
  assign gain_trim = act_cfg[GAIN_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_cnt   <= '0;
      act_cfg    <= '0;
      prev_cfg   <= '0;
      prev_v     <= 1'b0;
      burn_cfg   <= '0;
      burn_v     <= 1'b0;
      after_burn <= 1'b0;
      fuse_pgm   <= 1'b0;
      fuse_wdata <= '0;
      reload_q   <= 1'b0;
      boot_q     <= 1'b1;
      prog_err   <= 1'b0;
    end else begin
      boot_q   <= 1'b0;
      reload_q <= fuse_pgm;

      if (cs_fall)
        conv_cnt <= CNT_W'(CONV_CYCLES);
      else if (conv_cnt != '0)
        conv_cnt <= conv_cnt - CNT_W'(1);

      fuse_pgm <= cs_fall && burn_v;
      if (cs_fall && burn_v) begin
        fuse_wdata <= burn_cfg;
        burn_v     <= 1'b0;
      end

      if (boot_q || reload_q) begin
        act_cfg <= fuse_q;
      end else if (conv_end && prev_v) begin
        act_cfg <= prev_cfg;
        prev_v  <= 1'b0;
      end

      if (cs_rise) begin
        if (cmd_wr && cmd_prog) begin
          if (after_burn) begin
            prog_err   <= 1'b1;
            after_burn <= 1'b0;
          end else begin
            burn_cfg   <= cmd_cfg;
            burn_v     <= 1'b1;
            after_burn <= 1'b1;
          end
        end else begin
          after_burn <= 1'b0;
          if (cmd_wr) begin
            prev_cfg <= cmd_cfg;
            prev_v   <= 1'b1;
          end
        end
      end
    end
  end
endmodule

module otp_trim_ctrl_chk #(
  parameter int FILT_W = 3,
  parameter int GAIN_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_fall,
  input logic              fuse_pgm,
  input logic              conv_end,
  input logic              prog_err,
  input logic [FILT_W-1:0] filt_code,
  input logic [GAIN_W-1:0] gain_trim
);
  logic [1:0] up;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) up <= '0;
    else if (up != 2'd3) up <= up + 2'd1;

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_pgm |=> !fuse_pgm);
  a_r5_pulse_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (up != 2'd0 && fuse_pgm) |-> $past(cs_fall));
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    prog_err |=> prog_err);
  a_r4_conv_single: assert property (@(posedge clk) disable iff (!rst_n)
    conv_end |=> !conv_end);
  a_r3_change_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    (up == 2'd3 && !$stable({filt_code, gain_trim})) |->
      ($past(conv_end) || $past(fuse_pgm, 2)));
endmodule

bind otp_trim_ctrl otp_trim_ctrl_chk #(.FILT_W(FILT_W), .GAIN_W(GAIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .fuse_pgm(fuse_pgm),
  .conv_end(conv_end), .prog_err(prog_err),
  .filt_code(filt_code), .gain_trim(gain_trim)
);

// File: tb/otp_trim_ctrl_test.sv
module otp_trim_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_fall = 1'b0, cs_rise = 1'b0, cmd_wr = 1'b0, cmd_prog = 1'b0;
  logic [2:0] cmd_filt = '0;
  logic [5:0] cmd_gain = '0;
  logic [8:0] fuse = '0;
  logic       fuse_pgm, conv_end, prog_err;
  logic [8:0] fuse_wdata;
  logic [2:0] filt_code;
  logic [5:0] gain_trim;

  int n_chk = 0, n_fail = 0;
  logic [8:0] act_s [16];
  logic       ce_s  [16];
  logic       pg_s  [16];
  logic [8:0] wd0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) if (fuse_pgm) fuse <= fuse | fuse_wdata;

  otp_trim_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .cmd_wr(cmd_wr), .cmd_prog(cmd_prog), .cmd_filt(cmd_filt), .cmd_gain(cmd_gain),
    .fuse_q(fuse), .fuse_pgm(fuse_pgm), .fuse_wdata(fuse_wdata),
    .filt_code(filt_code), .gain_trim(gain_trim), .conv_end(conv_end), .prog_err(prog_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // index i = samples taken i edges after the edge that saw cs_fall
  task automatic frame(input bit wr, input bit prog, input logic [8:0] cfg, input int rise_at);
    @(negedge clk); cs_fall = 1'b1;
    @(negedge clk); cs_fall = 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (i > 0) @(negedge clk);
      cs_rise = 1'b0;
      act_s[i] = {filt_code, gain_trim};
      ce_s[i]  = conv_end;
      pg_s[i]  = fuse_pgm;
      if (i == 0) wd0 = fuse_wdata;
      if (i == rise_at - 1) begin
        cs_rise = 1'b1; cmd_wr = wr; cmd_prog = prog;
        {cmd_filt, cmd_gain} = cfg;
      end
    end
    cs_rise = 1'b0;
  endtask

  task automatic conv_ok(input string req);
    int hits = 0;
    for (int i = 0; i < 16; i++) if (ce_s[i]) hits++;
    chk(ce_s[7] && hits == 1, req, hits, 1);
  endtask

  task automatic no_pulse(input string req);
    int hits = 0;
    for (int i = 0; i < 16; i++) if (pg_s[i]) hits++;
    chk(hits == 0, req, hits, 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk({filt_code, gain_trim, fuse_pgm, conv_end, prog_err} == '0, "R1 reset outputs",
        {filt_code, gain_trim, fuse_pgm, conv_end, prog_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    logic [8:0] cur, exp_fuse;
    repeat (3) @(negedge clk);
    do_reset();
    chk({filt_code, gain_trim} == fuse, "R2 load blank fuses", {filt_code, gain_trim}, fuse);

    // R3/R4/R10: every preview value, plus read frames in between
    cur = '0;
    for (int v = 0; v < 512; v++) begin
      frame(1'b1, 1'b0, 9'(v), 4);
      chk(act_s[4] == cur, "R3 not before conv end", act_s[4], cur);
      chk(act_s[8] == 9'(v), "R3 applied at conv end", act_s[8], v);
      conv_ok("R4 conv strobe");
      no_pulse("R3 preview burns nothing");
      cur = 9'(v);
      if (v % 64 == 0) begin
        frame(1'b0, 1'b0, 9'h1ff, 4);
        chk(act_s[15] == cur, "R10 read frame ignored", act_s[15], cur);
      end
    end

    // R3 corner: cs_rise on the conv_end cycle waits for the next conversion
    frame(1'b1, 1'b0, 9'h0a5, 8);
    chk(act_s[15] == cur, "R3 same-cycle rise deferred", act_s[15], cur);
    frame(1'b0, 1'b0, 9'h000, 4);
    chk(act_s[7] == cur && act_s[8] == 9'h0a5, "R3 applied next conv", act_s[8], 9'h0a5);
    cur = 9'h0a5;

    // R5/R6/R7/R10: burns with overlapping bits
    exp_fuse = '0;
    for (int k = 0; k < 4; k++) begin
      logic [8:0] pv;
      pv = 9'(9'h111 << k) ^ 9'(k * 37);
      frame(1'b1, 1'b1, pv, 4);
      no_pulse("R5 no pulse in own frame");
      chk(act_s[15] == cur, "R10 program write leaves config", act_s[15], cur);
      frame(1'b0, 1'b0, 9'h000, 4);
      exp_fuse = exp_fuse | pv;
      chk(pg_s[0] && wd0 == pv, "R5 pulse data", wd0, pv);
      chk(!pg_s[1], "R6 pulse one cycle", pg_s[1], 0);
      chk(act_s[2] == exp_fuse && act_s[15] == exp_fuse, "R7 fuse OR reload", act_s[2], exp_fuse);
      cur = exp_fuse;
    end

    // R9: burned bits return after reset
    do_reset();
    chk({filt_code, gain_trim} == exp_fuse, "R9 fuses survive reset", {filt_code, gain_trim}, exp_fuse);
    chk(!prog_err, "R8 no error yet", prog_err, 0);

    // R8: back-to-back program writes
    frame(1'b1, 1'b1, 9'h003, 4);
    frame(1'b1, 1'b1, 9'h180, 4);
    chk(pg_s[0] && wd0 == 9'h003, "R8 first request burned", wd0, 9'h003);
    chk(prog_err, "R8 error set", prog_err, 1);
    frame(1'b0, 1'b0, 9'h000, 4);
    no_pulse("R8 second request dropped");
    exp_fuse = exp_fuse | 9'h003;
    chk(fuse == exp_fuse, "R8 fuse holds only first", fuse, exp_fuse);
    frame(1'b0, 1'b0, 9'h000, 4);
    chk(prog_err, "R8 error sticky", prog_err, 1);
    do_reset();
    chk(!prog_err && {filt_code, gain_trim} == exp_fuse, "R9 reload after error", {filt_code, gain_trim}, exp_fuse);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule